// File: doc/BRIEF.md
# DDR3 Device-Side Command Decoder with Bank State

This block sits on the memory-device side of a DDR3-style command and address bus. On every rising clock edge it samples chip select, the three command strobes, clock enable, the bank address and the row/column address. It turns that sample into one decoded command and applies the command to its internal model of the device.

For each of the banks, the block records whether a row is open and which row it is. It holds four mode registers, loaded by the mode-load command. From those registers and address bit 12 it works out the burst length of every read and write. It follows the power state that clock enable selects, and it gates the termination request with the termination setting held in the mode registers.

A downstream model or a protocol monitor uses the registered outputs: the decoded command, the access pulse and its burst length, a protocol-error pulse, and the bank and power state.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: When cs_ni is sampled high, the edge executes nothing. cmd_o shows NOP (0) after that edge and no bank or mode state changes, whatever the strobes carry.
- R2: With cs_ni low, {ras_ni,cas_ni,we_ni} decodes as follows: 011 activate, 101 read, 100 write, 010 precharge, 000 mode load, 001 refresh, anything else no-op. After the edge, cmd_o reports the command as NOP=0, ACT=1, RD=2, WR=3, PRE=4, MRS=5 or REF=6.
- R3: An activate to a closed bank sets bank_open_o[ba_i]. It also stores addr_i as that bank's row in open_row_o[ba_i*ADDR_W +: ADDR_W].
- R4: A precharge with addr_i[10]=0 closes only bank ba_i. With addr_i[10]=1 it closes every bank.
- R5: A read or write to an open bank with addr_i[10]=1 closes that bank at the same edge that reports the access. With addr_i[10]=0 the bank stays open.
- R6: A mode load writes addr_i into mode register ba_i[1:0]. Register k is visible at mode_regs_o[k*ADDR_W +: ADDR_W].
- R7: Each legal read or write pulses access_o for one cycle, with burst_len_o set as follows. If MR0[1:0]=00 or 11, the length is 8. If MR0[1:0]=10, it is 4. If MR0[1:0]=01, addr_i[12]=1 gives 8 and addr_i[12]=0 gives 4.
- R8: A read or write to a closed bank, or an activate to an open bank, pulses proto_err_o for one cycle. That command raises no access_o and leaves all bank state unchanged.
- R9: An edge in the active state with cke_i low changes pwr_state_o as follows. A refresh with every bank closed gives self refresh (3). Otherwise, any open bank gives active power-down (2), and no open bank gives precharge power-down (1).
- R10: Power-down is left at the first edge that samples cke_i high. Self refresh is left as soon as cke_i rises: pwr_state_o shows active (0) before any clock edge.
- R11: A command is executed only at an edge where the registered power state is active and cke_i is high. At any other edge, cmd_o shows NOP, apart from the self-refresh entry edge, which shows REF.
- R12: odt_en_o follows odt_i one edge later only while MR1 bit 9, bit 6 or bit 2 is set. When all three are clear, odt_en_o stays 0.
- R13: While rst_ni is low, and without waiting for a clock, all banks are closed, rows and mode registers are zero, the power state is active, and cmd_o, access_o, proto_err_o and odt_en_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| ba_i | input | BA_W | Bank address / mode register select |
| addr_i | input | ADDR_W | Row, column, flag and op-code bits |
| odt_i | input | 1 | Termination request |
| cmd_o | output | 3 | Decoded command of the last edge |
| access_o | output | 1 | One-cycle pulse for a legal read or write |
| burst_len_o | output | 4 | Burst length of the access (4 or 8) |
| proto_err_o | output | 1 | One-cycle protocol-error pulse |
| bank_open_o | output | 2**BA_W | Open flag per bank |
| open_row_o | output | 2**BA_W*ADDR_W | Open row per bank, bank 0 lowest |
| mode_regs_o | output | 4*ADDR_W | Mode registers 0..3, register 0 lowest |
| pwr_state_o | output | 2 | 0 active, 1 precharge PD, 2 active PD, 3 self refresh |
| odt_en_o | output | 1 | Termination applied |

## Verification
The bench builds the block with its defaults: eight banks (BA_W=3) and a 14-bit address. At this size both flag bits, A10 and A12, are present, so the bench can reach the all-bank precharge against several open banks and every burst-length mode. With eight banks, the precharge checks can show that a single-bank close leaves a neighbouring bank open. Power-state scenarios cover each entry path, the ignored exit edge, and the self-refresh exit that is taken before any clock edge.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_MRS = 3'd5,
    CMD_REF = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE   = 2'd0,
    PWR_PRE_PD   = 2'd1,
    PWR_ACT_PD   = 2'd2,
    PWR_SELF_REF = 2'd3
  } pwr_e;

  localparam int unsigned AP_BIT  = 10;
  localparam int unsigned BC_BIT  = 12;
  localparam int unsigned NUM_MR  = 4;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import ddr_cmd_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = CMD_REF;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/bank_table.sv
module bank_table #(
  parameter int unsigned BA_W  = 3,
  parameter int unsigned ROW_W = 14,
  localparam int unsigned NB   = 2 ** BA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                act_i,
  input  logic                close_one_i,
  input  logic                close_all_i,
  input  logic [BA_W-1:0]     bank_i,
  input  logic [ROW_W-1:0]    row_i,
  output logic [NB-1:0]       open_o,
  output logic [NB*ROW_W-1:0] row_o
);
  logic [NB-1:0] open_q;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             hit;
    logic [ROW_W-1:0] row_q;
    assign hit = (bank_i == BA_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q     <= '0;
      end else if (close_all_i || (close_one_i && hit)) begin
        open_q[b] <= 1'b0;
      end else if (act_i && hit) begin
        open_q[b] <= 1'b1;
        row_q     <= row_i;
      end
    end

    assign row_o[b*ROW_W +: ROW_W] = row_q;
  end

  assign open_o = open_q;

  assert_close_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_all_i |=> (open_q == '0));
  assert_act_opens_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !close_all_i && !close_one_i) |=> open_q[$past(bank_i)]);
endmodule

// File: rtl/mode_regs.sv
module mode_regs
  import ddr_cmd_pkg::*;
#(
  parameter int unsigned MR_W = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           sel_i,
  input  logic [MR_W-1:0]      op_i,
  input  logic                 chop_bit_i,
  output logic [NUM_MR*MR_W-1:0] mr_o,
  output logic [3:0]           blen_o,
  output logic                 rtt_on_o
);
  logic [MR_W-1:0] mr_q [NUM_MR];

  for (genvar k = 0; k < NUM_MR; k++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mr_q[k] <= '0;
      else if (we_i && sel_i == 2'(k))      mr_q[k] <= op_i;
    end
    assign mr_o[k*MR_W +: MR_W] = mr_q[k];
  end

  // MR0[1:0]: 00/11 fixed 8, 01 chop chosen per access, 10 fixed 4
  always_comb begin
    unique case (mr_q[0][1:0])
      2'b01:   blen_o = chop_bit_i ? 4'd8 : 4'd4;
      2'b10:   blen_o = 4'd4;
      default: blen_o = 4'd8;
    endcase
  end

  assign rtt_on_o = mr_q[1][9] | mr_q[1][6] | mr_q[1][2];

  assert_mrs_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mr_q[$past(sel_i)] == $past(op_i)));
endmodule

// File: rtl/power_fsm.sv
module power_fsm
  import ddr_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  cmd_e cmd_i,
  input  logic any_open_i,
  output logic exec_o,
  output logic sr_entry_o,
  output pwr_e pwr_o
);
  pwr_e st_q, st_d;

  assign exec_o     = (st_q == PWR_ACTIVE) && cke_i;
  assign sr_entry_o = (st_q == PWR_ACTIVE) && !cke_i && (cmd_i == CMD_REF) && !any_open_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PWR_ACTIVE: if (!cke_i) begin
        if (sr_entry_o)      st_d = PWR_SELF_REF;
        else if (any_open_i) st_d = PWR_ACT_PD;
        else                 st_d = PWR_PRE_PD;
      end
      default: if (cke_i) st_d = PWR_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PWR_ACTIVE;
    else         st_q <= st_d;
  end

  // self-refresh exit does not wait for a clock edge
  assign pwr_o = (st_q == PWR_SELF_REF && cke_i) ? PWR_ACTIVE : st_q;

  assert_pd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != PWR_ACTIVE && !cke_i) |=> $stable(st_q));
  assert_pd_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != PWR_ACTIVE && cke_i) |=> (st_q == PWR_ACTIVE));
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_cmd_pkg::*;
#(
  parameter int unsigned BA_W   = 3,
  parameter int unsigned ADDR_W = 14,
  localparam int unsigned NB    = 2 ** BA_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cke_i,
  input  logic                      cs_ni,
  input  logic                      ras_ni,
  input  logic                      cas_ni,
  input  logic                      we_ni,
  input  logic [BA_W-1:0]           ba_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      odt_i,
  output logic [2:0]                cmd_o,
  output logic                      access_o,
  output logic [3:0]                burst_len_o,
  output logic                      proto_err_o,
  output logic [NB-1:0]             bank_open_o,
  output logic [NB*ADDR_W-1:0]      open_row_o,
  output logic [NUM_MR*ADDR_W-1:0]  mode_regs_o,
  output logic [1:0]                pwr_state_o,
  output logic                      odt_en_o
);
  cmd_e       cmd_raw;
  logic       exec, sr_entry, tgt_open, is_rw;
  logic       act_en, acc_en, err_en, close_one, close_all, mrs_en;
  logic [3:0] blen;
  logic       rtt_on;
  pwr_e       pwr;
  logic [NB-1:0] open_vec;

  cmd_e       cmd_q;
  logic       acc_q, err_q, odt_q;
  logic [3:0] blen_q;

  cmd_decode u_dec (
    .cs_ni (cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .cmd_o (cmd_raw)
  );

  power_fsm u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cke_i      (cke_i),
    .cmd_i      (cmd_raw),
    .any_open_i (|open_vec),
    .exec_o     (exec),
    .sr_entry_o (sr_entry),
    .pwr_o      (pwr)
  );

  assign tgt_open  = open_vec[ba_i];
  assign is_rw     = (cmd_raw == CMD_RD) || (cmd_raw == CMD_WR);
  assign act_en    = exec && (cmd_raw == CMD_ACT) && !tgt_open;
  assign acc_en    = exec && is_rw && tgt_open;
  assign err_en    = exec && (((cmd_raw == CMD_ACT) && tgt_open) || (is_rw && !tgt_open));
  assign close_all = exec && (cmd_raw == CMD_PRE) && addr_i[AP_BIT];
  assign close_one = (exec && (cmd_raw == CMD_PRE) && !addr_i[AP_BIT]) ||
                     (acc_en && addr_i[AP_BIT]);
  assign mrs_en    = exec && (cmd_raw == CMD_MRS);

  bank_table #(.BA_W(BA_W), .ROW_W(ADDR_W)) u_banks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act_en),
    .close_one_i (close_one),
    .close_all_i (close_all),
    .bank_i      (ba_i),
    .row_i       (addr_i),
    .open_o      (open_vec),
    .row_o       (open_row_o)
  );

  mode_regs #(.MR_W(ADDR_W)) u_mr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (mrs_en),
    .sel_i      (ba_i[1:0]),
    .op_i       (addr_i),
    .chop_bit_i (addr_i[BC_BIT]),
    .mr_o       (mode_regs_o),
    .blen_o     (blen),
    .rtt_on_o   (rtt_on)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      acc_q  <= 1'b0;
      err_q  <= 1'b0;
      blen_q <= '0;
      odt_q  <= 1'b0;
    end else begin
      cmd_q  <= exec ? cmd_raw : (sr_entry ? CMD_REF : CMD_NOP);
      acc_q  <= acc_en;
      err_q  <= err_en;
      blen_q <= acc_en ? blen : blen_q;
      odt_q  <= odt_i && rtt_on;
    end
  end

  assign cmd_o       = cmd_q;
  assign access_o    = acc_q;
  assign burst_len_o = blen_q;
  assign proto_err_o = err_q;
  assign bank_open_o = open_vec;
  assign pwr_state_o = pwr;
  assign odt_en_o    = odt_q;

  assert_cs_mask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cmd_o == CMD_NOP));
  assert_err_no_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> !access_o);
  assert_err_banks_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_en |=> $stable(bank_open_o));
  assert_blen_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_o |-> (burst_len_o == 4'd4 || burst_len_o == 4'd8));
  assert_idle_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> (cmd_o == CMD_NOP || cmd_o == CMD_REF));
endmodule

// File: tb/tb_ddr_cmd_tracker.sv
module tb_ddr_cmd_tracker;
  localparam int  CLK_PERIOD = 10;
  localparam int  BA_W = 3;
  localparam int  AW   = 14;
  localparam int  NB   = 8;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_MRS = 3'b000, C_REF = 3'b001,
                         C_NOP = 3'b111;

  logic clk = 0, rst_n = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, odt = 0;
  logic [BA_W-1:0] ba = '0;
  logic [AW-1:0]   addr = '0;
  logic [2:0]      cmd_o;
  logic            access_o, proto_err_o, odt_en_o;
  logic [3:0]      burst_len_o;
  logic [NB-1:0]   bank_open_o;
  logic [NB*AW-1:0] open_row_o;
  logic [4*AW-1:0] mode_regs_o;
  logic [1:0]      pwr_state_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_cmd_tracker #(.BA_W(BA_W), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .odt_i(odt),
    .cmd_o(cmd_o), .access_o(access_o), .burst_len_o(burst_len_o),
    .proto_err_o(proto_err_o), .bank_open_o(bank_open_o), .open_row_o(open_row_o),
    .mode_regs_o(mode_regs_o), .pwr_state_o(pwr_state_o), .odt_en_o(odt_en_o)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a negedge, let one rising edge pass, return at the next negedge
  task automatic issue(input logic c, input logic [2:0] s, input logic [BA_W-1:0] b,
                       input logic [AW-1:0] a);
    cs_n = c; {ras_n, cas_n, we_n} = s; ba = b; addr = a;
    @(negedge clk);
    cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP;
  endtask

  function automatic logic [AW-1:0] row_of(input int b);
    return open_row_o[b*AW +: AW];
  endfunction

  task automatic t_reset;
    chk(bank_open_o, 0, "R13 banks");
    chk(open_row_o, 0, "R13 rows");
    chk(mode_regs_o, 0, "R13 mode regs");
    chk(pwr_state_o, 0, "R13 power");
    chk({cmd_o, access_o, proto_err_o, odt_en_o}, 0, "R13 outputs");
  endtask

  task automatic t_cs_mask;
    issue(1'b1, C_ACT, 3'd0, 14'h0123);
    chk(cmd_o, 0, "R1 masked cmd");
    chk(bank_open_o, 0, "R1 no bank change");
    issue(1'b1, C_MRS, 3'd0, 14'h0002);
    chk(mode_regs_o, 0, "R1 no mode change");
  endtask

  task automatic t_activate;
    issue(1'b0, C_ACT, 3'd3, 14'h1abc);
    chk(cmd_o, 1, "R2 ACT code");
    chk(bank_open_o, 8'b0000_1000, "R3 open flag");
    chk(row_of(3), 14'h1abc, "R3 row");
    issue(1'b0, C_ACT, 3'd3, 14'h0555);
    chk(proto_err_o, 1, "R8 act on open bank");
    chk(row_of(3), 14'h1abc, "R8 row unchanged");
    issue(1'b0, C_NOP, 3'd0, 14'h0);
    chk({cmd_o, proto_err_o}, 0, "R8 err one cycle / R2 NOP code");
    issue(1'b0, C_RD, 3'd5, 14'h0);
    chk({proto_err_o, access_o}, 2'b10, "R8 read closed bank");
    chk(cmd_o, 2, "R2 RD code");
    chk(bank_open_o, 8'b0000_1000, "R8 banks unchanged");
  endtask

  task automatic t_burst;
    issue(1'b0, C_MRS, 3'd0, 14'h0000);
    chk(cmd_o, 5, "R2 MRS code");
    issue(1'b0, C_RD, 3'd3, 14'h0000);
    chk({access_o, burst_len_o}, {1'b1, 4'd8}, "R7 fixed 8");
    issue(1'b0, C_MRS, 3'd0, 14'h0001);
    chk(mode_regs_o[0 +: AW], 14'h0001, "R6 MR0 written");
    issue(1'b0, C_RD, 3'd3, 14'h0000);
    chk({access_o, burst_len_o}, {1'b1, 4'd4}, "R7 otf A12 low chop 4");
    issue(1'b0, C_WR, 3'd3, 14'h1000);
    chk({access_o, burst_len_o}, {1'b1, 4'd8}, "R7 otf A12 high 8");
    chk(cmd_o, 3, "R2 WR code");
    issue(1'b0, C_MRS, 3'd0, 14'h0002);
    issue(1'b0, C_RD, 3'd3, 14'h1000);
    chk({access_o, burst_len_o}, {1'b1, 4'd4}, "R7 fixed 4");
    issue(1'b0, C_MRS, 3'd2, 14'h2a5a);
    chk(mode_regs_o[2*AW +: AW], 14'h2a5a, "R6 MR2 written");
    chk(mode_regs_o[0 +: AW], 14'h0002, "R6 MR0 kept");
    issue(1'b0, C_NOP, 3'd0, 14'h0);
    chk(access_o, 0, "R7 access one cycle");
  endtask

  task automatic t_autopre;
    issue(1'b0, C_RD, 3'd3, 14'h0000);
    chk(bank_open_o[3], 1, "R5 no AP keeps open");
    issue(1'b0, C_WR, 3'd3, 14'h0400);
    chk({access_o, bank_open_o[3]}, 2'b10, "R5 AP closes");
  endtask

  task automatic t_precharge;
    issue(1'b0, C_ACT, 3'd1, 14'h0011);
    issue(1'b0, C_ACT, 3'd2, 14'h0022);
    issue(1'b0, C_ACT, 3'd7, 14'h0077);
    chk(bank_open_o, 8'b1000_0110, "R3 three open");
    issue(1'b0, C_PRE, 3'd1, 14'h0000);
    chk(bank_open_o, 8'b1000_0100, "R4 single close");
    chk(cmd_o, 4, "R2 PRE code");
    issue(1'b0, C_PRE, 3'd0, 14'h0400);
    chk(bank_open_o, 0, "R4 all close");
  endtask

  task automatic t_power;
    cke = 0;
    issue(1'b0, C_ACT, 3'd0, 14'h0001);
    chk(pwr_state_o, 1, "R9 precharge PD");
    chk({cmd_o, bank_open_o[0]}, 0, "R11 no exec on entry");
    cke = 1;
    issue(1'b0, C_ACT, 3'd0, 14'h0001);
    chk(pwr_state_o, 0, "R10 PD exit on edge");
    chk(bank_open_o[0], 0, "R11 exit edge ignored");
    issue(1'b0, C_ACT, 3'd4, 14'h0044);
    cke = 0;
    issue(1'b0, C_NOP, 3'd0, 14'h0);
    chk(pwr_state_o, 2, "R9 active PD");
    issue(1'b0, C_NOP, 3'd0, 14'h0);
    chk(pwr_state_o, 2, "R9 active PD hold");
    cke = 1;
    issue(1'b0, C_NOP, 3'd0, 14'h0);
    issue(1'b0, C_PRE, 3'd0, 14'h0400);
    cke = 0;
    issue(1'b0, C_REF, 3'd0, 14'h0);
    chk(pwr_state_o, 3, "R9 self refresh");
    chk(cmd_o, 6, "R11 REF shown on SR entry");
    issue(1'b0, C_NOP, 3'd0, 14'h0);
    chk(pwr_state_o, 3, "R10 SR hold");
    cke = 1;
    #1;
    chk(pwr_state_o, 0, "R10 SR async exit");
    @(negedge clk);
    chk(pwr_state_o, 0, "R10 SR exit settled");
  endtask

  task automatic t_odt;
    odt = 1;
    issue(1'b0, C_NOP, 3'd0, 14'h0);
    chk(odt_en_o, 0, "R12 ODT ignored");
    issue(1'b0, C_MRS, 3'd1, 14'h0004);
    issue(1'b0, C_NOP, 3'd0, 14'h0);
    chk(odt_en_o, 1, "R12 ODT applied");
    odt = 0;
    issue(1'b0, C_NOP, 3'd0, 14'h0);
    chk(odt_en_o, 0, "R12 ODT follows input");
    odt = 1;
  endtask

  task automatic t_async_reset;
    issue(1'b0, C_ACT, 3'd6, 14'h0066);
    #2 rst_n = 0;
    #1;
    chk(bank_open_o, 0, "R13 async banks");
    chk(mode_regs_o, 0, "R13 async mode regs");
    chk(odt_en_o, 0, "R13 async odt");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pwr_state_o, 0, "R13 power after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_cs_mask;
    t_activate;
    t_burst;
    t_autopre;
    t_precharge;
    t_power;
    t_odt;
    t_async_reset;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule